// File: doc/BRIEF.md
# Per-Port EDID View with Physical-Address Patching

This block gives each of several display input ports its own view of one shared 512-byte identification image. Each port's read path presents a byte address. After one clock the block returns the byte that the port should see. Most bytes come straight from the shared RAM. Two bytes at a programmable offset are replaced by that port's own 16-bit physical address. The checksum byte of the 128-byte block that holds the offset is replaced by a value corrected for the substitution. The shared RAM is never rewritten, so one stored image serves every port.

To correct the checksum, the block needs the original bytes at the offset. It gets them by observing the RAM's write port and keeping a copy of every byte written to the offset or to the byte after it. The offset is therefore expected to be programmed before the image is loaded. A port whose enable is low reads 0xFF, which is what an undriven serial bus returns.

The serial protocol engine, the RAM and the host configuration registers sit outside this block. The RAM is assumed to have one read port per view, with one cycle of read latency.

Top module: `edid_port_view`

## Requirements
- R1: The address a port presents at a rising edge is passed to that port's RAM address output in the same cycle, and the resulting byte appears on the port's read data after that edge, so read data lags the address by one clock.
- R2: For an enabled port, any address other than the two physical-address bytes and the patched checksum byte returns the RAM byte unchanged.
- R3: For an enabled port, the address equal to the offset returns bits 15:8 of that port's physical address, and the address equal to offset+1 (modulo 512, so 0x1FF is followed by 0x000) returns bits 7:0.
- R4: For an enabled port, the last byte (low seven address bits all ones) of the 128-byte block holding the offset returns the stored byte plus the two original bytes minus the two substituted bytes, modulo 256. Checksum bytes of the other blocks pass through unchanged.
- R5: When a port's enable is 0 at the edge where its address is taken, that port's next read data is 0xFF.
- R6: Ports are independent. Reading the same address at the same time, each port sees its own physical-address bytes and its own checksum correction.
- R7: The original bytes used in R4 follow the last RAM writes to the offset and to offset+1, and both are 0 after reset, which matches a RAM cleared to zero.
- R8: When a physical-address byte falls on the checksum location (offset low seven bits 0x7E or 0x7F), the physical-address byte is returned there and no checksum is patched.
- R9: While reset is asserted, and on the first cycle after it, every port's read data is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_offset | input | ADDR_W | Byte offset of the high physical-address byte |
| mon_wr_en | input | 1 | Write strobe observed on the shared RAM's write port |
| mon_wr_addr | input | ADDR_W | Write address observed on the shared RAM |
| mon_wr_data | input | 8 | Write data observed on the shared RAM |
| port_en | input | NPORTS | Per-port view enable |
| port_pa | input | NPORTS*16 | Per-port physical address, port p at bits [16p+15:16p] |
| rd_addr | input | NPORTS*ADDR_W | Per-port read address |
| ram_addr | output | NPORTS*ADDR_W | Per-port RAM read address |
| ram_rdata | input | NPORTS*8 | Per-port RAM read data, one cycle after ram_addr |
| rd_data | output | NPORTS*8 | Per-port view data, one cycle after rd_addr |

## Verification
Every view byte is due on the cycle after the edge that takes its address. The RAM byte behind it arrives in that same cycle, and so does the copy of the original bytes that was written at an earlier edge. The bench drives inputs just after a falling edge and records what it drove. It then compares each port's read data at the next falling edge against a model evaluated on those recorded inputs. The model recomputes a patched checksum by summing the whole 128-byte block before and after substitution. RAM writes are issued only while every enable is low, so a write never lands in the same cycle as a read it would change.

// File: rtl/edid_view_pkg.sv
package edid_view_pkg;

  typedef enum logic [2:0] {
    VK_IDLE  = 3'd0,
    VK_RAM   = 3'd1,
    VK_PA_HI = 3'd2,
    VK_PA_LO = 3'd3,
    VK_CSUM  = 3'd4
  } view_kind_e;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  // Checksum after substitution: stored + (old bytes) - (new bytes), mod 256.
  function automatic logic [7:0] csum_adjust(input logic [7:0] stored,
                                             input logic [7:0] old_hi,
                                             input logic [7:0] old_lo,
                                             input logic [7:0] new_hi,
                                             input logic [7:0] new_lo);
    logic [7:0] old_sum;
    logic [7:0] new_sum;
    old_sum = old_hi + old_lo;
    new_sum = new_hi + new_lo;
    return stored + old_sum - new_sum;
  endfunction

  // Physical-address bytes take priority over the checksum slot.
  function automatic view_kind_e pick_kind(input logic en,
                                           input logic hit_hi,
                                           input logic hit_lo,
                                           input logic hit_csum);
    if (!en)           return VK_IDLE;
    else if (hit_hi)   return VK_PA_HI;
    else if (hit_lo)   return VK_PA_LO;
    else if (hit_csum) return VK_CSUM;
    else               return VK_RAM;
  endfunction

endpackage

// File: rtl/edid_pa_shadow.sv
module edid_pa_shadow #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pa_offset,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        orig_hi,
  output logic [7:0]        orig_lo
);

  logic [ADDR_W-1:0] lo_addr;
  logic              cap_hi;
  logic              cap_lo;

  assign lo_addr = pa_offset + ADDR_W'(1);
  assign cap_hi  = wr_en && (wr_addr == pa_offset);
  assign cap_lo  = wr_en && (wr_addr == lo_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      orig_hi <= '0;
      orig_lo <= '0;
    end else begin
      if (cap_hi) orig_hi <= wr_data;
      if (cap_lo) orig_lo <= wr_data;
    end
  end

  a_r7_hi_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == pa_offset) |=> (orig_hi == $past(wr_data)));

  a_r7_lo_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(pa_offset + 1'b1)) |=> (orig_lo == $past(wr_data)));

  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(orig_hi) && $stable(orig_lo)));

endmodule

// File: rtl/edid_view_classify.sv
module edid_view_classify
  import edid_view_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BLK_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] pa_offset,
  output view_kind_e        kind_q
);

  logic [ADDR_W-1:0] lo_addr;
  logic [ADDR_W-1:0] csum_addr;
  logic              hit_hi;
  logic              hit_lo;
  logic              hit_csum;
  view_kind_e        kind_d;

  assign lo_addr   = pa_offset + ADDR_W'(1);
  assign csum_addr = {pa_offset[ADDR_W-1:BLK_W], {BLK_W{1'b1}}};
  assign hit_hi    = (rd_addr == pa_offset);
  assign hit_lo    = (rd_addr == lo_addr);
  assign hit_csum  = (rd_addr == csum_addr);
  assign kind_d    = pick_kind(en, hit_hi, hit_lo, hit_csum);

  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= VK_IDLE;
    else        kind_q <= kind_d;
  end

  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (kind_q == VK_IDLE));

  a_r8_pa_over_csum: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit_csum && (hit_hi || hit_lo)) |=> (kind_q != VK_CSUM));

endmodule

// File: rtl/edid_byte_patch.sv
module edid_byte_patch
  import edid_view_pkg::*;
(
  input  view_kind_e  kind,
  input  logic [7:0]  ram_rdata,
  input  logic [15:0] pa_word,
  input  logic [7:0]  orig_hi,
  input  logic [7:0]  orig_lo,
  output logic [7:0]  rd_data
);

  always_comb begin
    unique case (kind)
      VK_RAM:   rd_data = ram_rdata;
      VK_PA_HI: rd_data = pa_word[15:8];
      VK_PA_LO: rd_data = pa_word[7:0];
      VK_CSUM:  rd_data = csum_adjust(ram_rdata, orig_hi, orig_lo,
                                      pa_word[15:8], pa_word[7:0]);
      default:  rd_data = IDLE_BYTE;
    endcase
  end

endmodule

// File: rtl/edid_port_view.sv
module edid_port_view
  import edid_view_pkg::*;
#(
  parameter int NPORTS = 3,
  parameter int ADDR_W = 9,
  parameter int BLK_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        pa_offset,
  input  logic                     mon_wr_en,
  input  logic [ADDR_W-1:0]        mon_wr_addr,
  input  logic [7:0]               mon_wr_data,
  input  logic [NPORTS-1:0]        port_en,
  input  logic [NPORTS*16-1:0]     port_pa,
  input  logic [NPORTS*ADDR_W-1:0] rd_addr,
  output logic [NPORTS*ADDR_W-1:0] ram_addr,
  input  logic [NPORTS*8-1:0]      ram_rdata,
  output logic [NPORTS*8-1:0]      rd_data
);

  localparam int PA_W = 16;

  logic [7:0] orig_hi;
  logic [7:0] orig_lo;

  edid_pa_shadow #(.ADDR_W(ADDR_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .pa_offset(pa_offset),
    .wr_en   (mon_wr_en),
    .wr_addr (mon_wr_addr),
    .wr_data (mon_wr_data),
    .orig_hi (orig_hi),
    .orig_lo (orig_lo)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [ADDR_W-1:0] addr_w;
    logic [PA_W-1:0]   pa_w;
    logic [7:0]        ram_w;
    logic [7:0]        out_w;
    view_kind_e        kind;

    assign addr_w = rd_addr[p*ADDR_W +: ADDR_W];
    assign pa_w   = port_pa[p*PA_W +: PA_W];
    assign ram_w  = ram_rdata[p*8 +: 8];
    assign ram_addr[p*ADDR_W +: ADDR_W] = addr_w;
    assign rd_data[p*8 +: 8] = out_w;

    edid_view_classify #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_classify (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (port_en[p]),
      .rd_addr  (addr_w),
      .pa_offset(pa_offset),
      .kind_q   (kind)
    );

    edid_byte_patch u_patch (
      .kind     (kind),
      .ram_rdata(ram_w),
      .pa_word  (pa_w),
      .orig_hi  (orig_hi),
      .orig_lo  (orig_lo),
      .rd_data  (out_w)
    );

    a_r5_disabled_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en[p] |=> (out_w == 8'hFF));

    a_r3_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en[p] && addr_w == pa_offset) |=> (out_w == pa_w[15:8]));

    a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en[p] && addr_w != pa_offset && addr_w == ADDR_W'(pa_offset + 1'b1))
      |=> (out_w == pa_w[7:0]));

    a_r4_checksum_balances: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en[p] && addr_w == {pa_offset[ADDR_W-1:BLK_W], {BLK_W{1'b1}}}
        && addr_w != pa_offset && addr_w != ADDR_W'(pa_offset + 1'b1))
      |=> (8'(out_w + pa_w[15:8] + pa_w[7:0]) == 8'(ram_w + orig_hi + orig_lo)));

    a_r2_plain_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en[p] && addr_w != pa_offset && addr_w != ADDR_W'(pa_offset + 1'b1)
        && addr_w != {pa_offset[ADDR_W-1:BLK_W], {BLK_W{1'b1}}})
      |=> (out_w == ram_w));
  end

endmodule

// File: tb/test_edid_port_view.sv
module test_edid_port_view;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int AW = 9;
  localparam int DEPTH = 512;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   pa_offset;
  logic            mon_wr_en;
  logic [AW-1:0]   mon_wr_addr;
  logic [7:0]      mon_wr_data;
  logic [NP-1:0]   port_en;
  logic [NP*16-1:0] port_pa;
  logic [NP*AW-1:0] rd_addr;
  logic [NP*AW-1:0] ram_addr;
  logic [NP*8-1:0]  ram_rdata;
  logic [NP*8-1:0]  rd_data;

  logic [7:0] mem [DEPTH];

  int    n_checks = 0;
  int    n_errors = 0;
  int    prev_addr [NP];
  bit    prev_en [NP];
  bit    prev_rst;
  string force_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  edid_port_view i_edid_port_view (
    .clk(clk), .rst_n(rst_n), .pa_offset(pa_offset),
    .mon_wr_en(mon_wr_en), .mon_wr_addr(mon_wr_addr), .mon_wr_data(mon_wr_data),
    .port_en(port_en), .port_pa(port_pa), .rd_addr(rd_addr),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .rd_data(rd_data)
  );

  // Shared RAM model: one-cycle read per port, written through the observed port.
  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) ram_rdata[p*8 +: 8] <= mem[ram_addr[p*AW +: AW]];
    if (mon_wr_en) mem[mon_wr_addr] <= mon_wr_data;
  end

  function automatic int lo_of(int off);
    return (off + 1) % DEPTH;
  endfunction

  function automatic int cs_of(int off);
    return (off / 128) * 128 + 127;
  endfunction

  function automatic logic [7:0] model(int p, int addr, bit en);
    int off = int'(pa_offset);
    logic [15:0] pa = port_pa[p*16 +: 16];
    int s = 0;
    int q = 0;
    if (!en) return 8'hFF;
    if (addr == off) return pa[15:8];
    if (addr == lo_of(off)) return pa[7:0];
    if (addr == cs_of(off)) begin
      for (int i = cs_of(off) - 127; i <= cs_of(off); i++) begin
        s += int'(mem[i]);
        if (i != cs_of(off)) begin
          if (i == off)            q += int'(pa[15:8]);
          else if (i == lo_of(off)) q += int'(pa[7:0]);
          else                     q += int'(mem[i]);
        end
      end
      return 8'((s - q) & 255);
    end
    return mem[addr];
  endfunction

  function automatic string tag_of(int addr, bit en, bit in_rst);
    int off = int'(pa_offset);
    if (in_rst) return "R9";
    if (force_tag != "") return force_tag;
    if (!en) return "R5";
    if ((addr == off || addr == lo_of(off)) && (off % 128) >= 126) return "R8";
    if (addr == off || addr == lo_of(off)) return "R3";
    if (addr == cs_of(off)) return "R4";
    return "R2";
  endfunction

  task automatic tick();
    for (int p = 0; p < NP; p++) begin
      prev_addr[p] = int'(rd_addr[p*AW +: AW]);
      prev_en[p]   = port_en[p];
    end
    prev_rst = !rst_n;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      logic [7:0] exp_b;
      logic [7:0] got;
      exp_b = prev_rst ? 8'hFF : model(p, prev_addr[p], prev_en[p]);
      got   = rd_data[p*8 +: 8];
      n_checks++;
      if (got !== exp_b) begin
        n_errors++;
        $display("FAIL %s port %0d addr %h actual=%h expected=%h",
                 tag_of(prev_addr[p], prev_en[p], prev_rst), p, prev_addr[p], got, exp_b);
      end
    end
  endtask

  task automatic set_port(int p, int addr, bit en);
    rd_addr[p*AW +: AW] = AW'(addr);
    port_en[p] = en;
  endtask

  task automatic all_read(int addr);
    for (int p = 0; p < NP; p++) set_port(p, addr, 1'b1);
    tick();
  endtask

  task automatic ram_write(int addr, logic [7:0] data);
    port_en     = '0;
    mon_wr_en   = 1'b1;
    mon_wr_addr = AW'(addr);
    mon_wr_data = data;
    tick();
    mon_wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    rst_n = 1'b0;
    pa_offset = 9'h094;
    mon_wr_en = 1'b0; mon_wr_addr = '0; mon_wr_data = '0;
    port_pa = {16'hC3D4, 16'h2100, 16'h1000};
    rd_addr = '0;
    port_en = '1;
    // R9: reset holds every view at 0xFF
    for (int k = 0; k < 3; k++) tick();
    rst_n = 1'b1;
    port_en = '0;
    tick();

    // Load the image through the observed write port (offset programmed first)
    for (int a = 0; a < DEPTH; a++) ram_write(a, 8'($urandom_range(0, 255)));

    // R1: random traffic, one-cycle latency on every port
    force_tag = "R1";
    for (int k = 0; k < 200; k++) begin
      for (int p = 0; p < NP; p++)
        set_port(p, $urandom_range(0, DEPTH - 1), ($urandom_range(0, 7) != 0));
      tick();
    end
    force_tag = "";

    // R2/R3/R4: directed addresses
    for (int k = 0; k < 2; k++) begin
      all_read(9'h094);
      all_read(9'h095);
      all_read(9'h0FF);
      all_read(9'h07F);
      all_read(9'h17F);
      all_read(9'h096);
      all_read(9'h000);
    end

    // R6: same address, distinct results per port
    force_tag = "R6";
    port_pa = {16'h4321, 16'hABCD, 16'h0F0F};
    all_read(9'h094);
    all_read(9'h095);
    all_read(9'h0FF);
    force_tag = "";

    // R5: disabled ports read 0xFF even at special addresses
    for (int p = 0; p < NP; p++) set_port(p, 9'h094, 1'b0);
    tick();
    for (int p = 0; p < NP; p++) set_port(p, 9'h0FF, 1'b0);
    tick();
    set_port(0, 9'h0FF, 1'b1); set_port(1, 9'h0FF, 1'b0); set_port(2, 9'h094, 1'b0);
    tick();

    // R7: rewriting the original bytes moves the checksum correction
    ram_write(9'h094, 8'h5A);
    ram_write(9'h095, 8'hE7);
    force_tag = "R7";
    all_read(9'h0FF);
    ram_write(9'h094, 8'h00);
    all_read(9'h0FF);
    pa_offset = 9'h010;
    ram_write(9'h010, 8'h33);
    ram_write(9'h011, 8'h44);
    all_read(9'h07F);
    all_read(9'h010);
    force_tag = "";

    // R8: address bytes sitting on the checksum slot
    port_en = '0;
    pa_offset = 9'h17E;
    tick();
    all_read(9'h17E);
    all_read(9'h17F);
    all_read(9'h17D);
    pa_offset = 9'h07F;
    port_en = '0;
    tick();
    all_read(9'h07F);
    all_read(9'h080);
    all_read(9'h0FF);

    // R3: wrap from the top address to zero
    pa_offset = 9'h1FF;
    port_en = '0;
    tick();
    all_read(9'h1FF);
    all_read(9'h000);
    all_read(9'h001);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule